// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller with Per-Source Bypass

This block gathers 32 level-sensitive interrupt sources in front of a primary interrupt controller. Software enables sources by writing ones to a set-enable register and disables them by writing ones to a clear-enable register. Every source that is raised, enabled and not bypassed shows in a pending register, and the OR of the pending bits forms one merged request. The merged request is wired to input 31 of the primary controller.

A bypass register lets chosen sources skip the merge. A source whose bypass bit is set no longer feeds the merged request or the pending register. It is presented on the same-numbered bit of a 32-bit bypass vector, which the primary controller ORs into its own inputs. A typical setup bypasses sources 20 and 22 to 31 (bypass word 0xFFD00000). Interrupt handlers read the pending register, or a companion register that returns the lowest pending source number directly, and service sources from the lowest number upward.

The register port is a simple single-cycle select/write strobe. Read data is registered and appears one clock after the read request. Reset is asynchronous and active low. Its release is synchronized inside the block, so the block leaves reset two clock edges after the reset input rises.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, the enable and bypass registers are all zero. The merged request is low and the bypass vector is zero for any source pattern. Register reads return zero.
- R2: A write to address 1 (set-enable) sets every enable bit whose write-data bit is 1 and leaves all other enable bits unchanged. Reading address 1 returns the enable word.
- R3: A write to address 2 (clear-enable) clears every enable bit whose write-data bit is 1 and leaves all other enable bits unchanged. Reading address 2 also returns the enable word.
- R4: Reading address 0 (pending) returns source AND enable AND NOT bypass, taken in the request cycle and presented on the read data after the next clock edge.
- R5: The merged request is high in the same cycle exactly when at least one pending bit is set.
- R6: Bypass vector bit n equals source n AND bypass bit n, whatever the enable bits hold.
- R7: A bypassed source never sets the merged request or its pending bit, even when it is enabled.
- R8: Reading address 4 (lowest pending) returns bit 5 = 1 with bits 4:0 holding the lowest-numbered pending source. When nothing is pending it returns all zeros.
- R9: Writes to the read-only addresses 0 and 4 and to the unused addresses 5 to 7 change neither the enable nor the bypass word. Reads of the unused addresses return zero.
- R10: Sources are level-sensitive and nothing is latched. When a source drops, its pending bit and its part in the merged request go away in the same cycle.
- R11: Address 3 (bypass) loads the whole write word on a write and returns it on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Level interrupt sources |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| merged_irq_o | output | 1 | Merged request to primary input 31 |
| pass_vec_o | output | 32 | Bypassed sources to same-numbered primary inputs |

## Verification
The bench targets the partial-update rules of the set and clear writes. A design that loaded the word instead of merging it would wipe enables that should survive. It enables sources that are also bypassed, to catch a design that still counts them in the merged request and pending word, or one that gates the bypass vector with the enable bits. It checks the lowest-pending register with source 0, source 31 and a lowest source that drops away, because an encoder that prefers the highest index or holds stale state returns the wrong number. It writes to the read-only and unused addresses; a loose decoder would corrupt the enable or bypass word there.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PEND   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENSET  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_BYPASS = 3'd3;
  localparam logic [ADDR_W-1:0] A_FIRST  = 3'd4;
endpackage

// File: rtl/sic_bitreg.sv
// Mask register: LOAD_MODE=0 gives set/clear semantics, 1 gives plain load.
module sic_bitreg #(
  parameter int W = 32,
  parameter bit LOAD_MODE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;
  logic         ce;

  assign ce = wr_a | wr_b;

  generate
    if (LOAD_MODE) begin : g_load
      always_comb begin
        nxt = q;
        if (wr_a) nxt = wbits;
      end
    end else begin : g_setclr
      always_comb begin
        nxt = q;
        if (wr_a)      nxt = q | wbits;
        else if (wr_b) nxt = q & ~wbits;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= nxt;
  end
endmodule

// File: rtl/sic_route.sv
// Splits sources into the merged path and the bypass path.
module sic_route #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] en,
  input  logic [W-1:0] bp,
  output logic [W-1:0] pend,
  output logic         merged,
  output logic [W-1:0] pass
);
  always_comb begin
    pend   = src & en & ~bp;
    merged = |pend;
    pass   = src & bp;
  end
endmodule

// File: rtl/sic_first.sv
// Lowest-index priority encoder over the pending word.
module sic_first #(
  parameter int W = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     pend,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sic_regbus.sv
// Address decode for writes and registered read mux.
module sic_regbus
  import sic_pkg::*;
#(
  parameter int W = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      en,
  input  logic [W-1:0]      bp,
  input  logic [W-1:0]      pend,
  input  logic              first_vld,
  input  logic [IDX_W-1:0]  first_idx,
  output logic              wr_enset,
  output logic              wr_enclr,
  output logic              wr_bypass,
  output logic [W-1:0]      rdata
);
  logic         rd_req;
  logic [W-1:0] rd_nxt;

  assign rd_req    = bus_sel & ~bus_wr;
  assign wr_enset  = bus_sel & bus_wr & (bus_addr == A_ENSET);
  assign wr_enclr  = bus_sel & bus_wr & (bus_addr == A_ENCLR);
  assign wr_bypass = bus_sel & bus_wr & (bus_addr == A_BYPASS);

  always_comb begin
    rd_nxt = '0;
    case (bus_addr)
      A_PEND:            rd_nxt = pend;
      A_ENSET, A_ENCLR:  rd_nxt = en;
      A_BYPASS:          rd_nxt = bp;
      A_FIRST:           rd_nxt = {{(W-IDX_W-1){1'b0}}, first_vld, first_idx};
      default:           rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= rd_nxt;
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import sic_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              merged_irq_o,
  output logic [N_SRC-1:0]  pass_vec_o
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic             wr_enset, wr_enclr, wr_bypass;
  logic [N_SRC-1:0] en_q, bp_q, pend;
  logic             first_vld;
  logic [IDX_W-1:0] first_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  sic_regbus #(.W(N_SRC)) u_bus (
    .clk(clk), .rst_n(rst_q_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .en(en_q), .bp(bp_q), .pend(pend),
    .first_vld(first_vld), .first_idx(first_idx),
    .wr_enset(wr_enset), .wr_enclr(wr_enclr), .wr_bypass(wr_bypass),
    .rdata(bus_rdata)
  );

  sic_bitreg #(.W(N_SRC), .LOAD_MODE(1'b0)) u_en (
    .clk(clk), .rst_n(rst_q_n), .wr_a(wr_enset), .wr_b(wr_enclr),
    .wbits(bus_wdata), .q(en_q)
  );

  sic_bitreg #(.W(N_SRC), .LOAD_MODE(1'b1)) u_bp (
    .clk(clk), .rst_n(rst_q_n), .wr_a(wr_bypass), .wr_b(1'b0),
    .wbits(bus_wdata), .q(bp_q)
  );

  sic_route #(.W(N_SRC)) u_route (
    .src(src_i), .en(en_q), .bp(bp_q),
    .pend(pend), .merged(merged_irq_o), .pass(pass_vec_o)
  );

  sic_first #(.W(N_SRC)) u_first (
    .pend(pend), .valid(first_vld), .idx(first_idx)
  );
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk
  import sic_pkg::*;
#(
  parameter int W = 32,
  localparam int IDX_W = $clog2(W)
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      src_i,
  input logic              merged_irq_o,
  input logic [W-1:0]      pass_vec_o,
  input logic [W-1:0]      en,
  input logic [W-1:0]      bp
);
  // R2
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_sel && bus_wr && bus_addr == A_ENSET) |=> ((en & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_sel && bus_wr && bus_addr == A_ENCLR) |=> ((en & $past(bus_wdata)) == '0));
  // R4
  a_r4_pend_agrees: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_sel && !bus_wr && bus_addr == A_PEND) |=> ((bus_rdata != '0) == $past(merged_irq_o)));
  // R6
  a_r6_pass_needs_src: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((pass_vec_o & ~src_i) == '0));
  // R7
  a_r7_bypass_excluded: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((src_i & ~bp) == '0) |-> !merged_irq_o);
  // R8
  a_r8_first_valid: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_sel && !bus_wr && bus_addr == A_FIRST) |=> (bus_rdata[IDX_W] == $past(merged_irq_o)));
  // R9
  a_r9_ro_write: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_sel && bus_wr && (bus_addr == A_PEND || bus_addr >= A_FIRST)) |=> ($stable(en) && $stable(bp)));
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(.W(N_SRC)) u_chk (
  .clk(clk), .rst_ok_n(rst_q_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .src_i(src_i), .merged_irq_o(merged_irq_o), .pass_vec_o(pass_vec_o),
  .en(en_q), .bp(bp_q)
);

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_i;
  logic          bus_sel, bus_wr;
  logic [2:0]    bus_addr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;
  logic          merged_irq_o;
  logic [N-1:0]  pass_vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] mdl_en, mdl_bp;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_issued = 1'b0;
  logic         chk_due = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cascade_irq_ctrl #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .merged_irq_o(merged_irq_o), .pass_vec_o(pass_vec_o)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare registered read data with queued expectations.
  always @(posedge clk) chk_due <= rd_issued;
  always @(negedge clk) begin
    if (chk_due && exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  function automatic logic [N-1:0] mdl_pend();
    return src_i & mdl_en & ~mdl_bp;
  endfunction

  function automatic logic [N-1:0] mdl_first();
    logic [N-1:0] p;
    p = mdl_pend();
    for (int i = 0; i < N; i++)
      if (p[i]) return 32'h20 | 32'(i);
    return '0;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    case (a)
      3'd1: mdl_en = mdl_en | d;
      3'd2: mdl_en = mdl_en & ~d;
      3'd3: mdl_bp = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_issued = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; rd_issued = 1'b0;
  endtask

  task automatic set_src(input logic [N-1:0] s);
    @(negedge clk);
    src_i = s;
    #1;
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " merged"}, {31'b0, merged_irq_o}, {31'b0, |mdl_pend()});
    chk({tag, " pass"}, pass_vec_o, src_i & mdl_bp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; src_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; mdl_en = '0; mdl_bp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    set_src('1);
    chk("R1 merged after reset", {31'b0, merged_irq_o}, '0);
    chk("R1 pass after reset", pass_vec_o, '0);
    bus_read(3'd1, '0, "R1 enable read");
    bus_read(3'd3, '0, "R1 bypass read");
    bus_read(3'd0, '0, "R1 pend read");
    bus_read(3'd4, '0, "R1 first read");

    // R2 / R4 / R5 / R8 basic pending
    set_src(32'h0000_0010);
    bus_write(3'd1, 32'h0000_00F0);
    #1 chk_outs("R5 single source");
    bus_read(3'd0, 32'h0000_0010, "R4 pend single");
    bus_read(3'd4, 32'h24, "R8 first idx4");
    bus_write(3'd1, 32'h0000_0003);
    bus_read(3'd1, 32'h0000_00F3, "R2 set merges");

    // R3 partial clear, read through both addresses
    bus_write(3'd2, 32'h0000_0030);
    bus_read(3'd2, 32'h0000_00C3, "R3 clear partial");
    bus_read(3'd1, 32'h0000_00C3, "R3 enable word");

    // R11 / R7 / R6 bypass
    bus_write(3'd3, 32'hFFD0_0000);
    bus_read(3'd3, 32'hFFD0_0000, "R11 bypass readback");
    bus_write(3'd1, '1);
    set_src('1);
    chk("R6 pass vector", pass_vec_o, 32'hFFD0_0000);
    bus_read(3'd0, 32'h002F_FFFF, "R7 pend excludes bypass");
    bus_read(3'd4, 32'h20, "R8 first idx0");
    set_src(32'hFFD0_0000);
    chk("R7 bypass only merged", {31'b0, merged_irq_o}, '0);
    bus_read(3'd0, '0, "R7 pend empty");
    bus_write(3'd2, '1);
    set_src(32'h8000_0000);
    chk("R6 pass ignores enable", pass_vec_o, 32'h8000_0000);
    chk_outs("R6 outs disabled");

    // R9 read-only / unused addresses
    bus_write(3'd0, 32'h1234_5678);
    bus_write(3'd4, '1);
    bus_write(3'd6, '1);
    bus_read(3'd1, mdl_en, "R9 enable untouched");
    bus_read(3'd3, mdl_bp, "R9 bypass untouched");
    bus_read(3'd5, '0, "R9 unused reads zero");

    // R10 level behaviour and lowest ordering
    bus_write(3'd1, 32'h0040_0220);
    set_src(32'h0040_0220);
    chk_outs("R10 two sources");
    bus_read(3'd4, 32'h25, "R8 first idx5");
    set_src(32'h0040_0200);
    bus_read(3'd4, 32'h29, "R10 first moves to idx9");
    set_src(32'h0040_0000);
    chk("R10 merged drops", {31'b0, merged_irq_o}, '0);
    chk("R10 pass bit22", pass_vec_o, 32'h0040_0000);

    // R8 top source
    bus_write(3'd3, '0);
    bus_write(3'd1, '1);
    set_src(32'h8000_0000);
    chk_outs("R5 top source");
    bus_read(3'd4, 32'h3F, "R8 first idx31");
    bus_read(3'd0, mdl_pend(), "R4 pend top");
    bus_read(3'd4, mdl_first(), "R8 first model");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule